// File: doc/BRIEF.md
# Radix-2 Butterfly Address Sequencer for Row-wise FFT

This block drives the memory side of an in-place radix-2 FFT that is applied to every row of a two-dimensional complex array. A one-cycle start pulse captures three settings: the number of rows, the transform length given as its base-2 logarithm, and the row pitch, which is the address distance between the first elements of two neighbouring rows. The block then walks every row in turn. For each butterfly it offers a pair of element addresses and a valid strobe. A downstream datapath accepts the pair by holding `ready` high.

Inside one stage, the butterflies are grouped by twiddle index. All butterflies that use the same twiddle value are offered back to back. A step marker flags the last butterfly of each group, so a twiddle generator that works by recurrence knows when to rotate. A stage marker flags the first butterfly of each stage, so that generator can return to unity. When the last butterfly of the last row has been accepted, a done pulse follows and the block goes idle. The block does not touch memory, perform arithmetic, reorder inputs into bit-reversed order or produce twiddle values.

Top module: `fft_bfly_seq`

## Requirements
- R1: While reset is high, and after it is released with no start given, `bf_valid`, `tw_step`, `stage_first` and `done` are all low.
- R2: When `start` is high at a clock edge while the block is idle, `row_count`, `log2n` and `row_pitch` are captured. If the job is not empty, the first butterfly is offered in the cycle that follows that edge, with `stage_first` high.
- R3: For row r with base address r*pitch, and for each stage s from 0 to log2n-1, let h = 2^s and p = 2^(s+1). Twiddle index j runs from 0 up to h-1. For each j, index i runs from j in steps of p while i < 2^log2n. Each butterfly carries `addr_a` = base+i and `addr_b` = base+i+h, both taken modulo 2^ADDR_W. Butterflies are offered in exactly this order, and rows are processed in ascending order.
- R4: `tw_step` is high on a butterfly exactly when it is the last one of its twiddle group, that is when i+p >= 2^log2n.
- R5: `stage_first` is high on a butterfly exactly when j = 0 and i = 0. This happens once per stage of every row.
- R6: A butterfly is accepted only at an edge where `bf_valid` and `ready` are both high. While `ready` is low, the offered butterfly and its markers stay unchanged.
- R7: `done` is high for exactly one cycle, the cycle after the edge that accepts the final butterfly. `bf_valid` is low in that cycle, and the block is idle in the cycle after it.
- R8: A `start` pulse that arrives while a job is running has no effect on the sequence being produced.
- R9: A start with `row_count` = 0 or `log2n` = 0 offers no butterflies and raises `done` in the cycle after the start edge. `log2n` must not exceed MAX_LOG2N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; honoured only when idle |
| ready | input | 1 | Datapath accepts the offered butterfly |
| row_count | input | ROW_W | Number of rows to transform |
| log2n | input | LG_W | Base-2 log of transform length |
| row_pitch | input | ADDR_W | Address distance between rows |
| bf_valid | output | 1 | A butterfly is being offered |
| addr_a | output | ADDR_W | Upper element address of the pair |
| addr_b | output | ADDR_W | Lower element address of the pair |
| tw_step | output | 1 | Last butterfly of its twiddle group |
| stage_first | output | 1 | First butterfly of a stage |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The outputs are driven straight from registers, so the first butterfly appears one edge after the start edge. Each later butterfly appears one edge after the edge that accepted the previous one, and `done` appears one edge after the final acceptance. For an empty job, `done` appears one edge after start. The bench changes `ready` and `start` at the falling edge and samples the outputs a moment later. It compares the offered pair against its own list only when it has just set `ready` high, and this is the pair the next rising edge will accept. While `ready` is low, it checks that the pending entry is still on show. It checks for `done` in the cycle right after the last accepted entry, and checks that the block is idle in the cycle after that.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } seq_state_t;

    // Position markers of the butterfly currently held by the loop counters.
    typedef struct packed {
        logic stage_first;
        logic group_last;
        logic row_last;
    } loop_flags_t;

    function automatic logic job_empty(input logic zero_rows, input logic zero_len);
        return zero_rows | zero_len;
    endfunction

endpackage

// File: rtl/fft_seq_loops.sv
module fft_seq_loops
    import fft_seq_pkg::*;
#(
    parameter int MAX_LOG2N = 10,
    parameter int LG_W      = $clog2(MAX_LOG2N + 1),
    parameter int IDX_W     = MAX_LOG2N + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [LG_W-1:0]  log2n,
    output logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] half_span,
    output loop_flags_t      flags
);

    logic [LG_W-1:0]  stg;
    logic [IDX_W-1:0] grp;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] half;
    logic [IDX_W-1:0] span;
    logic [IDX_W-1:0] len;
    logic [IDX_W:0]   nxt;
    logic             last_grp;
    logic             last_stg;

    always_comb begin
        half     = IDX_W'(1) << stg;
        span     = half << 1;
        len      = IDX_W'(1) << log2n;
        nxt      = {1'b0, idx} + {1'b0, span};
        last_grp = (grp == half - IDX_W'(1));
        last_stg = (stg == log2n - LG_W'(1));
        flags.stage_first = (grp == '0) && (idx == '0);
        flags.group_last  = (nxt >= {1'b0, len});
        flags.row_last    = flags.group_last && last_grp && last_stg;
    end

    // Group-major walk: inner index strides by the span, the group index
    // advances once its inner run is exhausted, then the stage advances.
    always_ff @(posedge clk) begin
        if (rst || load) begin
            stg <= '0;
            grp <= '0;
            idx <= '0;
        end else if (step) begin
            if (flags.group_last) begin
                if (last_grp) begin
                    grp <= '0;
                    idx <= '0;
                    stg <= last_stg ? '0 : stg + LG_W'(1);
                end else begin
                    grp <= grp + IDX_W'(1);
                    idx <= grp + IDX_W'(1);
                end
            end else begin
                idx <= nxt[IDX_W-1:0];
            end
        end
    end

    assign idx_i     = idx;
    assign half_span = half;

endmodule

// File: rtl/fft_seq_addr.sv
module fft_seq_addr #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 11
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [IDX_W-1:0]  half_span,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b
);

    logic [ADDR_W-1:0] idx_e;
    logic [ADDR_W-1:0] half_e;

    generate
        if (IDX_W >= ADDR_W) begin : g_trunc
            assign idx_e  = idx_i[ADDR_W-1:0];
            assign half_e = half_span[ADDR_W-1:0];
        end else begin : g_ext
            assign idx_e  = {{(ADDR_W-IDX_W){1'b0}}, idx_i};
            assign half_e = {{(ADDR_W-IDX_W){1'b0}}, half_span};
        end
    endgenerate

    assign addr_a = base + idx_e;
    assign addr_b = addr_a + half_e;

endmodule

// File: rtl/fft_bfly_seq.sv
module fft_bfly_seq
    import fft_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROW_W     = 8,
    parameter int MAX_LOG2N = 10,
    parameter int LG_W      = $clog2(MAX_LOG2N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ready,
    input  logic [ROW_W-1:0]  row_count,
    input  logic [LG_W-1:0]   log2n,
    input  logic [ADDR_W-1:0] row_pitch,
    output logic              bf_valid,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b,
    output logic              tw_step,
    output logic              stage_first,
    output logic              done
);

    localparam int IDX_W = MAX_LOG2N + 1;

    seq_state_t        state;
    logic [LG_W-1:0]   lg_q;
    logic [ROW_W-1:0]  rows_q;
    logic [ROW_W-1:0]  row;
    logic [ADDR_W-1:0] pitch_q;
    logic [ADDR_W-1:0] base;
    logic              take;
    logic              fire;
    logic [IDX_W-1:0]  idx_i;
    logic [IDX_W-1:0]  half_span;
    loop_flags_t       flags;

    assign take = (state == ST_IDLE) && start;
    assign fire = (state == ST_RUN) && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            lg_q    <= '0;
            rows_q  <= '0;
            pitch_q <= '0;
            row     <= '0;
            base    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    lg_q    <= log2n;
                    rows_q  <= row_count;
                    pitch_q <= row_pitch;
                    row     <= '0;
                    base    <= '0;
                    state   <= job_empty(row_count == '0, log2n == '0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: if (fire && flags.row_last) begin
                    if (row == rows_q - ROW_W'(1)) begin
                        state <= ST_FIN;
                    end else begin
                        row  <= row + ROW_W'(1);
                        base <= base + pitch_q;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    fft_seq_loops #(
        .MAX_LOG2N(MAX_LOG2N),
        .LG_W     (LG_W),
        .IDX_W    (IDX_W)
    ) u_loops (
        .clk      (clk),
        .rst      (rst),
        .load     (take),
        .step     (fire),
        .log2n    (lg_q),
        .idx_i    (idx_i),
        .half_span(half_span),
        .flags    (flags)
    );

    fft_seq_addr #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_addr (
        .base     (base),
        .idx_i    (idx_i),
        .half_span(half_span),
        .addr_a   (addr_a),
        .addr_b   (addr_b)
    );

    assign bf_valid    = (state == ST_RUN);
    assign tw_step     = bf_valid && flags.group_last;
    assign stage_first = bf_valid && flags.stage_first;
    assign done        = (state == ST_FIN);

endmodule

// File: rtl/fft_bfly_seq_chk.sv
module fft_bfly_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              bf_valid,
    input logic [ADDR_W-1:0] addr_a,
    input logic [ADDR_W-1:0] addr_b,
    input logic              tw_step,
    input logic              stage_first,
    input logic              done
);

    logic [ADDR_W-1:0] gap;
    assign gap = addr_b - addr_a;

    a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
        bf_valid && !ready |=> bf_valid && $stable(addr_a) && $stable(addr_b)
                               && $stable(tw_step) && $stable(stage_first));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !bf_valid);

    a_r3_pair_gap: assert property (@(posedge clk) disable iff (rst)
        bf_valid |-> $countones(gap) == 1);

    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> !bf_valid && !done);

endmodule

bind fft_bfly_seq fft_bfly_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .bf_valid   (bf_valid),
    .addr_a     (addr_a),
    .addr_b     (addr_b),
    .tw_step    (tw_step),
    .stage_first(stage_first),
    .done       (done)
);

// File: tb/sim_fft_bfly_seq.sv
module sim_fft_bfly_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int ROW_W      = 8;
    localparam int MAX_LOG2N  = 10;
    localparam int LG_W       = $clog2(MAX_LOG2N + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              ready = 1'b0;
    logic [ROW_W-1:0]  row_count = '0;
    logic [LG_W-1:0]   log2n = '0;
    logic [ADDR_W-1:0] row_pitch = '0;
    logic              bf_valid;
    logic [ADDR_W-1:0] addr_a;
    logic [ADDR_W-1:0] addr_b;
    logic              tw_step;
    logic              stage_first;
    logic              done;

    int total_chk = 0;
    int bad_chk   = 0;
    int exp_n;
    int exp_a  [0:1023];
    int exp_b  [0:1023];
    int exp_tw [0:1023];
    int exp_sf [0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    fft_bfly_seq #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .MAX_LOG2N(MAX_LOG2N), .LG_W(LG_W)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .ready(ready),
        .row_count(row_count), .log2n(log2n), .row_pitch(row_pitch),
        .bf_valid(bf_valid), .addr_a(addr_a), .addr_b(addr_b),
        .tw_step(tw_step), .stage_first(stage_first), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total_chk++;
        if (!ok) begin
            bad_chk++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Reference walk of the group-major butterfly order.
    task automatic build(input int lg, input int rows, input int pitch);
        int n;
        n = 1 << lg;
        exp_n = 0;
        if (lg == 0) return;
        for (int r = 0; r < rows; r++)
            for (int s = 0; s < lg; s++) begin
                int h;
                int p;
                h = 1 << s;
                p = h * 2;
                for (int j = 0; j < h; j++)
                    for (int i = j; i < n; i += p) begin
                        exp_a[exp_n]  = (r * pitch + i) & 32'hFFFF;
                        exp_b[exp_n]  = (r * pitch + i + h) & 32'hFFFF;
                        exp_tw[exp_n] = (i + p >= n) ? 1 : 0;
                        exp_sf[exp_n] = (j == 0 && i == 0) ? 1 : 0;
                        exp_n++;
                    end
            end
    endtask

    task automatic run_case(input int lg, input int rows, input int pitch,
                            input int ready_pct, input bit inject);
        int idx;
        int cyc;
        bit seen_done;
        build(lg, rows, pitch);
        @(negedge clk);
        start     = 1'b1;
        log2n     = LG_W'(lg);
        row_count = ROW_W'(rows);
        row_pitch = ADDR_W'(pitch);
        @(negedge clk);
        idx = 0;
        cyc = 0;
        seen_done = 1'b0;
        while (!seen_done && cyc < 5000) begin
            ready = (($urandom % 100) < ready_pct);
            if (inject && cyc == 3) begin
                start     = 1'b1;          // R8: ignored while running
                log2n     = LG_W'((lg == 1) ? 2 : 1);
                row_count = ROW_W'(5);
                row_pitch = ADDR_W'(pitch + 3);
            end else begin
                start = 1'b0;
            end
            #1;
            if (cyc == 0) begin
                if (exp_n == 0)
                    check(done && !bf_valid, "R9", "empty job done", int'(done), 1);
                else
                    check(bf_valid && stage_first, "R2", "first offer", int'(bf_valid), 1);
            end
            if (done) begin
                seen_done = 1'b1;
                check(idx == exp_n && !bf_valid, "R7", "count at done", idx, exp_n);
            end else if (bf_valid) begin
                if (idx >= exp_n) begin
                    check(1'b0, "R3", "extra butterfly", idx, exp_n);
                end else if (ready) begin
                    check(int'(addr_a) == exp_a[idx] && int'(addr_b) == exp_b[idx],
                          "R3", "addr_a", int'(addr_a), exp_a[idx]);
                    check(int'(tw_step) == exp_tw[idx], "R4", "tw_step",
                          int'(tw_step), exp_tw[idx]);
                    check(int'(stage_first) == exp_sf[idx], "R5", "stage_first",
                          int'(stage_first), exp_sf[idx]);
                    idx++;
                end else begin
                    check(int'(addr_a) == exp_a[idx] && int'(addr_b) == exp_b[idx],
                          "R6", "pending addr_a", int'(addr_a), exp_a[idx]);
                end
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(seen_done, "R7", "job finished", cyc, 5000);
        #1;
        check(!done && !bf_valid, "R7", "idle after done", int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "WD", "watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        check(!bf_valid && !tw_step && !stage_first && !done, "R1", "in reset",
              int'(bf_valid), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(!bf_valid && !tw_step && !stage_first && !done, "R1", "idle after reset",
              int'(done), 0);

        run_case(3, 2, 20, 100, 1'b0);   // n = 8
        run_case(4, 3, 16, 60, 1'b0);    // n = 16 with stalls
        run_case(4, 1, 0, 30, 1'b1);     // heavy stall, restart attempt
        run_case(3, 2, 40, 50, 1'b1);
        run_case(0, 2, 5, 100, 1'b0);    // R9 zero length
        run_case(3, 0, 5, 100, 1'b0);    // R9 zero rows
        run_case(1, 3, 7, 70, 1'b0);
        run_case(4, 2, 65530, 80, 1'b0); // address wrap
        for (int k = 0; k < 6; k++)
            run_case(1 + int'($urandom % 5), 1 + int'($urandom % 4),
                     int'($urandom % 300), 20 + int'($urandom % 81), k[0]);

        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

endmodule